// File: doc/BRIEF.md
# Serial DAC Input Frame Receiver

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. An active-low select line, a serial clock and a data line come in asynchronously. They are resynchronised into the system clock domain and assembled into 24-bit words, most significant bit first. When a frame is complete, the block updates a held 16-bit conversion code and a 2-bit power mode. It decodes that mode into the enables for the output termination.

A frame is accepted only when exactly 24 falling serial-clock edges arrive while select is low. If select rises earlier, the partial word is thrown away. Edges after the 24th are ignored until select rises again. A frame that selects a power-down termination changes only the mode and leaves the held code alone. A ready flag drops while the converter is powered down. It also stays low for a parameterised wake-up interval after the block returns to normal operation.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `code_out` is 0, `term_mode` is 00, `amp_on` and `out_ready` are 1, and the three termination outputs are 0.
- R2: Data is sampled on falling `sclk` edges while `sel_n` is low, first bit is frame bit 23. On the 24th edge of a frame whose mode field is 00, `code_out` takes frame bits 15..0 (straight binary).
- R3: The mode field is frame bits 17..16. It takes effect in `term_mode` in the same cycle as the code update.
- R4: Frame bits 23..18 have no effect on any output.
- R5: If `sel_n` rises after fewer than 24 falling edges, neither `code_out` nor `term_mode` changes. The partial bits are cleared, so the next full frame is received correctly.
- R6: Falling `sclk` edges after the 24th within the same select-low period are ignored.
- R7: A new frame starts only on a falling edge of `sel_n`. Edges that arrive while select stays low after a completed frame write nothing.
- R8: The termination outputs are decoded from `term_mode`, and exactly one is high: 00 gives `amp_on`, 01 gives `pull_1k`, 10 gives `pull_100k` and 11 gives `float_out`.
- R9: A committed frame with mode 01, 10 or 11 leaves `code_out` unchanged.
- R10: `out_ready` is 0 while `term_mode` is not 00. When a frame changes the mode from power-down to 00, `out_ready` stays 0 for `WAKE_CYCLES` system clocks and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| code_out | output | 16 | Held conversion code |
| term_mode | output | 2 | Held power mode |
| amp_on | output | 1 | Amplifier drives the output (mode 00) |
| pull_1k | output | 1 | Output pulled down by low resistance (mode 01) |
| pull_100k | output | 1 | Output pulled down by high resistance (mode 10) |
| float_out | output | 1 | Output left open (mode 11) |
| out_ready | output | 1 | Output valid: normal mode and wake-up complete |

## Verification
The held code is driven with a walking one across all 16 code bits, and then with all-zero and all-one words. A bit-order or bit-offset error shows up as a misplaced single bit. Every mode value is sent with a fresh code, which separates mode decoding from preservation of the code in power-down. Select is released after each length from 0 to 23 edges, and frames are also sent with trailing edges or with select held low. These cases show whether the commit is tied to exactly the 24th edge of a properly opened frame. The wake-up sweep returns from each power-down mode and samples the ready flag inside and after the wake interval.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int FRAME_BITS = 24;
  parameter int CODE_BITS  = 16;
  parameter int MODE_BITS  = 2;
  parameter int MODE_LSB   = CODE_BITS;

  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_LOW_R  = 2'b01,
    PD_HIGH_R = 2'b10,
    PD_OPEN   = 2'b11
  } pd_mode_e;

  function automatic logic [CODE_BITS-1:0] frame_code(input logic [FRAME_BITS-1:0] w);
    return w[CODE_BITS-1:0];
  endfunction

  function automatic logic [MODE_BITS-1:0] frame_mode(input logic [FRAME_BITS-1:0] w);
    return w[MODE_LSB +: MODE_BITS];
  endfunction

  function automatic logic is_powerdown(input logic [MODE_BITS-1:0] m);
    return m != PD_NORMAL;
  endfunction

  // one-hot {open, high_r, low_r, normal}
  function automatic logic [3:0] term_decode(input logic [MODE_BITS-1:0] m);
    logic [3:0] r;
    r = 4'b0000;
    r[m] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d[g];
        s2 <= s1;
      end
    end
    assign q[g] = s2;
  end
endmodule

// File: rtl/sdac_frame_shift.sv
module sdac_frame_shift #(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_s,
  input  logic              din_s,
  output logic              commit,
  output logic [WORD_W-1:0] word,
  output logic              sclk_fall,
  output logic              sel_fall,
  output logic              sel_rise,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {FR_IDLE, FR_SHIFT, FR_DONE} fr_state_e;

  fr_state_e         state;
  logic              sel_d, sclk_d;
  logic [WORD_W-1:0] shreg;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sel_fall  = sel_d & ~sel_s;
  assign sel_rise  = ~sel_d & sel_s;
  assign word      = {shreg[WORD_W-2:0], din_s};
  assign commit    = (state == FR_SHIFT) && !sel_s && sclk_fall && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d  <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      sel_d  <= sel_s;
      sclk_d <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sel_s) begin
      state   <= FR_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      case (state)
        FR_IDLE: if (sel_fall) begin
          state   <= FR_SHIFT;
          shreg   <= '0;
          bit_cnt <= '0;
        end
        FR_SHIFT: if (sclk_fall) begin
          shreg <= word;
          if (bit_cnt == LAST) begin
            state   <= FR_DONE;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdac_wake_timer.sv
module sdac_wake_timer #(
  parameter int MODE_W      = 2,
  parameter int WAKE_CYCLES = 125,
  localparam int WCNT_W     = $clog2(WAKE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [MODE_W-1:0] new_mode,
  input  logic [MODE_W-1:0] cur_mode,
  output logic              ready
);
  localparam logic [WCNT_W-1:0] WAKE_LOAD = WCNT_W'(WAKE_CYCLES);

  logic [WCNT_W-1:0] cnt;
  logic              wake_start;

  assign wake_start = commit && (new_mode == '0) && (cur_mode != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b1;
    end else if (commit && new_mode != '0) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (wake_start) begin
      cnt   <= WAKE_LOAD;
      ready <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == WCNT_W'(1)) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
  import sdac_pkg::*;
#(
  parameter int WORD_W      = FRAME_BITS,
  parameter int CODE_W      = CODE_BITS,
  parameter int MODE_W      = MODE_BITS,
  parameter int WAKE_CYCLES = 125,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] code_out,
  output logic [MODE_W-1:0] term_mode,
  output logic              amp_on,
  output logic              pull_1k,
  output logic              pull_100k,
  output logic              float_out,
  output logic              out_ready
);
  logic [2:0]        sync_q;
  logic              commit_ev, sclk_fall, sel_fall, sel_rise;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  logic [MODE_W-1:0] cmd_mode;
  logic [CODE_W-1:0] cmd_code;
  logic [3:0]        term_1h;

  sdac_sync #(.N(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdin}), .q(sync_q)
  );

  sdac_frame_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_s(sync_q[2]), .sclk_s(sync_q[1]), .din_s(sync_q[0]),
    .commit(commit_ev), .word(word), .sclk_fall(sclk_fall),
    .sel_fall(sel_fall), .sel_rise(sel_rise), .bit_cnt(bit_cnt)
  );

  assign cmd_mode = frame_mode(word);
  assign cmd_code = frame_code(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_out  <= '0;
      term_mode <= PD_NORMAL;
    end else if (commit_ev) begin
      term_mode <= cmd_mode;
      if (!is_powerdown(cmd_mode)) code_out <= cmd_code;
    end
  end

  sdac_wake_timer #(.MODE_W(MODE_W), .WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .commit(commit_ev),
    .new_mode(cmd_mode), .cur_mode(term_mode), .ready(out_ready)
  );

  assign term_1h   = term_decode(term_mode);
  assign amp_on    = term_1h[0];
  assign pull_1k   = term_1h[1];
  assign pull_100k = term_1h[2];
  assign float_out = term_1h[3];
endmodule

// File: rtl/sdac_frame_rx_chk.sv
module sdac_frame_rx_chk #(
  parameter int CODE_W = 16,
  parameter int MODE_W = 2,
  parameter int CNT_W  = 5,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_ev,
  input logic              sclk_fall,
  input logic              sel_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [MODE_W-1:0] cmd_mode,
  input logic [CODE_W-1:0] code_out,
  input logic [MODE_W-1:0] term_mode,
  input logic              amp_on,
  input logic              pull_1k,
  input logic              pull_100k,
  input logic              float_out,
  input logic              out_ready
);
  p_code_only_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(code_out));

  p_mode_only_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(term_mode));

  p_mode_takes_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> term_mode == $past(cmd_mode));

  p_commit_on_last_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> (sclk_fall && bit_cnt == CNT_W'(WORD_W - 1)));

  p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> bit_cnt == '0);

  p_term_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({float_out, pull_100k, pull_1k, amp_on}) == 1);

  p_pd_keeps_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && cmd_mode != '0) |=> $stable(code_out));

  p_not_ready_in_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    term_mode != '0 |-> !out_ready);

  p_wake_drops_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && cmd_mode == '0 && term_mode != '0) |=> !out_ready);
endmodule

bind sdac_frame_rx sdac_frame_rx_chk #(
  .CODE_W(CODE_W), .MODE_W(MODE_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_ev(commit_ev), .sclk_fall(sclk_fall),
  .sel_rise(sel_rise), .bit_cnt(bit_cnt), .cmd_mode(cmd_mode),
  .code_out(code_out), .term_mode(term_mode), .amp_on(amp_on),
  .pull_1k(pull_1k), .pull_100k(pull_100k), .float_out(float_out),
  .out_ready(out_ready)
);

// File: tb/sdac_frame_rx_bench.sv
module sdac_frame_rx_bench;
  localparam int WAKE = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic [15:0] code_out;
  logic [1:0]  term_mode;
  logic        amp_on, pull_1k, pull_100k, float_out, out_ready;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic [15:0] exp_code = '0;
  logic [1:0]  exp_mode = '0;

  always #10 clk = ~clk;

  sdac_frame_rx #(.WAKE_CYCLES(WAKE)) u_sdac_frame_rx (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .code_out(code_out), .term_mode(term_mode), .amp_on(amp_on),
    .pull_1k(pull_1k), .pull_100k(pull_100k), .float_out(float_out),
    .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected one-hot {float, 100k, 1k, amp} for a mode value
  function automatic logic [3:0] exp_term(input logic [1:0] m);
    case (m)
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic check_state(input string req);
    chk(req, {16'h0, code_out}, {16'h0, exp_code});
    chk(req, {30'h0, term_mode}, {30'h0, exp_mode});
    chk(req, {28'h0, float_out, pull_100k, pull_1k, amp_on}, {28'h0, exp_term(exp_mode)});
  endtask

  // drive nedges falling sclk edges with sel_n low; optionally release sel_n
  task automatic frame(input logic [23:0] w, input int nedges, input bit release_sel);
    @(negedge clk);
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      sdin = (i < 24) ? w[23 - i] : i[0];
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (release_sel) sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // model a completed frame
  task automatic model_commit(input logic [23:0] w);
    exp_mode = w[17:16];
    if (w[17:16] == 2'b00) exp_code = w[15:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk("R1", {31'h0, out_ready}, 32'h1);

    // R2 walking one over every code bit, mode 00
    for (int b = 0; b < 16; b++) begin
      logic [23:0] w;
      w = {6'h00, 2'b00, 16'(1 << b)};
      frame(w, 24, 1'b1);
      model_commit(w);
      check_state("R2");
      chk("R2", {31'h0, out_ready}, 32'h1);
    end
    frame(24'h00FFFF, 24, 1'b1); model_commit(24'h00FFFF); check_state("R2");
    frame(24'h000000, 24, 1'b1); model_commit(24'h000000); check_state("R2");

    // R4 ignored upper bits
    for (int k = 0; k < 6; k++) begin
      logic [23:0] w;
      w = {6'(1 << k), 2'b00, 16'hA5C3 ^ 16'(k * 16'h1111)};
      frame(w, 24, 1'b1);
      model_commit(w);
      check_state("R4");
    end
    frame(24'hFC1234, 24, 1'b1); model_commit(24'h001234); check_state("R4");

    // R3 R8 R9 R10 each power-down mode, then return to normal
    for (int m = 1; m < 4; m++) begin
      logic [23:0] w;
      w = {6'h00, 2'(m), 16'hBEEF - 16'(m)};
      frame(w, 24, 1'b1);
      model_commit(w);
      check_state("R9");
      chk("R3", {30'h0, term_mode}, 32'(m));
      chk("R10", {31'h0, out_ready}, 32'h0);
      w = {6'h00, 2'b00, 16'h3000 + 16'(m)};
      frame(w, 24, 1'b1);
      model_commit(w);
      check_state("R8");
      chk("R10", {31'h0, out_ready}, 32'h0);
      repeat (WAKE) @(negedge clk);
      chk("R10", {31'h0, out_ready}, 32'h1);
    end

    // R5 abort after every partial length, then a full frame still works
    for (int n = 0; n < 24; n++) begin
      frame({6'h00, 2'(n % 4), 16'(16'hF0F0 ^ 16'(n))}, n, 1'b1);
      check_state("R5");
    end
    frame(24'h00_1357, 24, 1'b1); model_commit(24'h00_1357); check_state("R5");

    // R6 trailing edges after the 24th
    frame(24'h00_9ABC, 32, 1'b1); model_commit(24'h00_9ABC); check_state("R6");
    frame(24'h00_0F0F, 40, 1'b1); model_commit(24'h00_0F0F); check_state("R6");

    // R7 select held low: second burst needs a new falling select
    frame(24'h00_4444, 24, 1'b0); model_commit(24'h00_4444); check_state("R7");
    frame(24'h00_7777, 24, 1'b1); check_state("R7");
    frame(24'h00_7777, 24, 1'b1); model_commit(24'h00_7777); check_state("R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule